// File: doc/BRIEF.md
# Key-Protected Power Mode Controller

This block is the power management register file of a mixed-signal sensing chip. A simple register bus (address, write data, write strobe, combinational read data) writes a mode register, a low-power block power-down register and a low-power clock-select register. The block turns their contents into control lines for clock gating, retention, the ADC power switch, analog power-down and low-frequency clock selection. It also keeps track of whether the chip is active, hibernating or shut down.

The mode register and the two low-power registers each sit behind an unlock key. A correct key value written to the matching key address opens exactly one later write to the protected register or registers. Any other bus write in between, or a wrong key value, closes the gate again. A write that arrives while the gate is closed leaves the register unchanged and sets a sticky error bit. A wake input returns the chip from a low-power state to active mode.

Top module: `pwr_mode_ctrl`

Byte addresses: 0x00 mode, 0x04 mode key, 0x08 low-power key, 0x0C low-power clock select, 0x10 low-power power-down, 0x14 status.

## Requirements
- R1: After reset, the mode register reads 0x0001, the low-power power-down and clock-select registers read 0, the status register reads 0 and the state is active.
- R2: A write to the mode register without a correct mode key leaves the register unchanged and sets status bit 0.
- R3: Writing 0x4859 to the mode key address allows exactly one following write to the mode register. A second write without a new key is blocked.
- R4: A wrong key value, or any other bus write between the key and the protected write, closes the gate again.
- R5: Writing 0x000C59D6 to the low-power key address allows one following write to either the power-down register or the clock-select register. A write to either register without the key is blocked and sets status bit 1.
- R6: The mode register keeps only bit 15 (RAM retention), bit 14 (ADC switch retention) and bits [1:0] (mode). The power-down register keeps bits [LP_W-1:0] and the clock-select register keeps bit 0. All other bits, and both key addresses, read as zero.
- R7: One cycle after the mode field changes, the state follows it: 2 means hibernate, 3 means shutdown, and 1 or 0 means active. The state reads at status bits [5:4] as 0 for active, 1 for hibernate and 2 for shutdown.
- R8: hs_clk_gate_o is 1 exactly when the state is not active.
- R9: ram_ret_o equals mode bit 15 outside the active state and is 0 when active. adc_sw_on_o is 1 when active and equals mode bit 14 otherwise.
- R10: lp_pd_o mirrors the power-down register in the active and hibernate states and is all ones in shutdown.
- R11: sys_clk_lf_o is 1 outside the active state. When active, it is 1 only when clock-select bit 0 and seq_lf_req_i are both 1.
- R12: wake_i outside the active state sets the mode field to 1 and keeps bits 15 and 14. In the active state it has no effect.
- R13: Status error bits stay set until a write to the status address with a 1 in that bit position clears them. A new error in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| wake_i | input | 1 | Wake request from the always-on domain |
| seq_lf_req_i | input | 1 | Sequencer request to run the system clock from the 32 kHz oscillator |
| hs_clk_gate_o | output | 1 | Gate the high-speed clock and power down its oscillator |
| adc_sw_on_o | output | 1 | ADC power switch enable |
| ram_ret_o | output | 1 | RAM retention enable |
| lp_pd_o | output | LP_W | Per-block analog power-down, bit 1 is the high-power reference |
| sys_clk_lf_o | output | 1 | Select the 32 kHz oscillator as the system clock |

## Verification
A gate left open by mistake, or one closed by mistake, shows on the next read of the protected register and as a wrong status error bit within one cycle of the write. A state register that lags or picks the wrong decode shows in the cycle after the mode change, as wrong values on the clock-gate, retention, switch and power-down pins and at status bits [5:4]. The bench keeps a behavioural copy of the register contents and compares every output pin and the read data on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned ADR_MODE   = 'h00;
  localparam int unsigned ADR_MKEY   = 'h04;
  localparam int unsigned ADR_LKEY   = 'h08;
  localparam int unsigned ADR_LCLK   = 'h0C;
  localparam int unsigned ADR_LCFG   = 'h10;
  localparam int unsigned ADR_STATUS = 'h14;

  localparam logic [31:0] MODE_KEY_VAL = 32'h0000_4859;
  localparam logic [31:0] LP_KEY_VAL   = 32'h000C_59D6;

  localparam logic [1:0] MODE_ACTIVE = 2'd1;
  localparam logic [1:0] MODE_HIB    = 2'd2;
  localparam logic [1:0] MODE_SHDN   = 2'd3;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_HIB    = 2'd1,
    ST_SHDN   = 2'd2
  } pmc_state_e;

  typedef struct packed {
    logic       ram_ret;
    logic       adc_ret;
    logic [1:0] mode;
  } mode_reg_t;

  localparam mode_reg_t MODE_RST = '{ram_ret: 1'b0, adc_ret: 1'b0, mode: MODE_ACTIVE};
endpackage

// File: rtl/pmc_key_gate.sv
module pmc_key_gate #(
  parameter int unsigned DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              key_sel_i,
  input  logic              tgt_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              accept_o,
  output logic              block_o
);
  logic unlocked_q;

  // every write re-arms the gate; only the exact key opens it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   unlocked_q <= 1'b0;
    else if (we_i) unlocked_q <= key_sel_i && (wdata_i == KEY_VAL);
  end

  assign accept_o = we_i && tgt_sel_i && unlocked_q;
  assign block_o  = we_i && tgt_sel_i && !unlocked_q;

  assert_one_shot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
endmodule

// File: rtl/pmc_state_trk.sv
module pmc_state_trk
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output pmc_state_e state_o
);
  pmc_state_e state_d, state_q;

  always_comb begin
    case (mode_i)
      MODE_HIB:  state_d = ST_HIB;
      MODE_SHDN: state_d = ST_SHDN;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_hib_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HIB) |=> (state_o == ST_HIB));
  assert_shdn_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SHDN) |=> (state_o == ST_SHDN));
endmodule

// File: rtl/pmc_out_map.sv
module pmc_out_map
  import pmc_pkg::*;
#(
  parameter int unsigned LP_W = 16
) (
  input  pmc_state_e      state_i,
  input  mode_reg_t       mode_i,
  input  logic [LP_W-1:0] lp_cfg_i,
  input  logic            lp_clk_en_i,
  input  logic            seq_lf_req_i,
  output logic            hs_clk_gate_o,
  output logic            adc_sw_on_o,
  output logic            ram_ret_o,
  output logic [LP_W-1:0] lp_pd_o,
  output logic            sys_clk_lf_o
);
  logic low_pwr;
  logic shdn;

  assign low_pwr       = (state_i != ST_ACTIVE);
  assign shdn          = (state_i == ST_SHDN);
  assign hs_clk_gate_o = low_pwr;
  assign ram_ret_o     = low_pwr && mode_i.ram_ret;
  assign adc_sw_on_o   = !low_pwr || mode_i.adc_ret;
  assign sys_clk_lf_o  = low_pwr || (lp_clk_en_i && seq_lf_req_i);

  for (genvar b = 0; b < LP_W; b++) begin : g_pd
    assign lp_pd_o[b] = shdn || lp_cfg_i[b];
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LP_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  output logic [31:0]       rdata_o,
  input  logic              wake_i,
  input  logic              seq_lf_req_i,
  output logic              hs_clk_gate_o,
  output logic              adc_sw_on_o,
  output logic              ram_ret_o,
  output logic [LP_W-1:0]   lp_pd_o,
  output logic              sys_clk_lf_o
);
  localparam int unsigned ERR_W = 2;

  logic sel_mode, sel_mkey, sel_lkey, sel_lclk, sel_lcfg, sel_stat;
  assign sel_mode = (addr_i == ADDR_W'(ADR_MODE));
  assign sel_mkey = (addr_i == ADDR_W'(ADR_MKEY));
  assign sel_lkey = (addr_i == ADDR_W'(ADR_LKEY));
  assign sel_lclk = (addr_i == ADDR_W'(ADR_LCLK));
  assign sel_lcfg = (addr_i == ADDR_W'(ADR_LCFG));
  assign sel_stat = (addr_i == ADDR_W'(ADR_STATUS));

  logic mode_acc, mode_blk, lp_acc, lp_blk;

  pmc_key_gate #(.DATA_W(32), .KEY_VAL(MODE_KEY_VAL)) u_mode_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .key_sel_i (sel_mkey),
    .tgt_sel_i (sel_mode),
    .wdata_i   (wdata_i),
    .accept_o  (mode_acc),
    .block_o   (mode_blk)
  );

  pmc_key_gate #(.DATA_W(32), .KEY_VAL(LP_KEY_VAL)) u_lp_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .key_sel_i (sel_lkey),
    .tgt_sel_i (sel_lclk || sel_lcfg),
    .wdata_i   (wdata_i),
    .accept_o  (lp_acc),
    .block_o   (lp_blk)
  );

  mode_reg_t       mode_q;
  logic [LP_W-1:0] lp_cfg_q;
  logic            lp_clk_q;
  logic [ERR_W-1:0] err_q, err_clr, err_set;
  pmc_state_e      state;
  logic            wake_hit;

  assign wake_hit = wake_i && (state != ST_ACTIVE);

  // an accepted bus write takes priority over a wake in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
    end else if (mode_acc) begin
      mode_q.ram_ret <= wdata_i[15];
      mode_q.adc_ret <= wdata_i[14];
      mode_q.mode    <= wdata_i[1:0];
    end else if (wake_hit) begin
      mode_q.mode <= MODE_ACTIVE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_cfg_q <= '0;
      lp_clk_q <= 1'b0;
    end else if (lp_acc) begin
      if (sel_lcfg) lp_cfg_q <= wdata_i[LP_W-1:0];
      if (sel_lclk) lp_clk_q <= wdata_i[0];
    end
  end

  assign err_clr = (we_i && sel_stat) ? wdata_i[ERR_W-1:0] : '0;
  assign err_set = {lp_blk, mode_blk};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (err_q & ~err_clr) | err_set;
  end

  pmc_state_trk u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_q.mode),
    .state_o (state)
  );

  pmc_out_map #(.LP_W(LP_W)) u_out (
    .state_i       (state),
    .mode_i        (mode_q),
    .lp_cfg_i      (lp_cfg_q),
    .lp_clk_en_i   (lp_clk_q),
    .seq_lf_req_i  (seq_lf_req_i),
    .hs_clk_gate_o (hs_clk_gate_o),
    .adc_sw_on_o   (adc_sw_on_o),
    .ram_ret_o     (ram_ret_o),
    .lp_pd_o       (lp_pd_o),
    .sys_clk_lf_o  (sys_clk_lf_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_mode) begin
      rdata_o[15]  = mode_q.ram_ret;
      rdata_o[14]  = mode_q.adc_ret;
      rdata_o[1:0] = mode_q.mode;
    end
    if (sel_lcfg) rdata_o[LP_W-1:0] = lp_cfg_q;
    if (sel_lclk) rdata_o[0] = lp_clk_q;
    if (sel_stat) begin
      rdata_o[ERR_W-1:0] = err_q;
      rdata_o[5:4]       = state;
    end
  end

  assert_blocked_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_blk && !wake_hit) |=> (mode_q == $past(mode_q)));
  assert_lp_blocked_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_blk |=> ((lp_cfg_q == $past(lp_cfg_q)) && (lp_clk_q == $past(lp_clk_q))));
  assert_err_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q[0] && !err_clr[0]) |=> err_q[0]);
  assert_wake_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_hit && !mode_acc) |=> (mode_q.mode == MODE_ACTIVE));
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int LP_W   = 16;
  localparam int A_MODE = 'h00, A_MKEY = 'h04, A_LKEY = 'h08;
  localparam int A_LCLK = 'h0C, A_LCFG = 'h10, A_STAT = 'h14;
  localparam logic [31:0] K_MODE = 32'h0000_4859;
  localparam logic [31:0] K_LP   = 32'h000C_59D6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic we_i = 1'b0;
  logic wake_i = 1'b0;
  logic seq_lf_req_i = 1'b0;
  logic [31:0] rdata_o;
  logic hs_clk_gate_o, adc_sw_on_o, ram_ret_o, sys_clk_lf_o;
  logic [LP_W-1:0] lp_pd_o;

  always #5 clk_i = ~clk_i;

  pwr_mode_ctrl #(.ADDR_W(ADDR_W), .LP_W(LP_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .wake_i(wake_i), .seq_lf_req_i(seq_lf_req_i),
    .hs_clk_gate_o(hs_clk_gate_o), .adc_sw_on_o(adc_sw_on_o), .ram_ret_o(ram_ret_o),
    .lp_pd_o(lp_pd_o), .sys_clk_lf_o(sys_clk_lf_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode, m_lcfg, m_lclk, m_err, m_st;
  bit m_mul, m_lul;

  function automatic int dec_state(input int md);
    if ((md & 3) == 2) return 1;
    if ((md & 3) == 3) return 2;
    return 0;
  endfunction

  function automatic int mdl_read(input int a);
    if (a == A_MODE) return m_mode;
    if (a == A_LCFG) return m_lcfg;
    if (a == A_LCLK) return m_lclk;
    if (a == A_STAT) return m_err | (m_st << 4);
    return 0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_mode = 1; m_lcfg = 0; m_lclk = 0; m_err = 0; m_st = 0; m_mul = 0; m_lul = 0;
    end else begin
      int n_mode, n_lcfg, n_lclk, n_err, a, d;
      bit acc;
      n_mode = m_mode; n_lcfg = m_lcfg; n_lclk = m_lclk; n_err = m_err; acc = 0;
      a = int'(addr_i); d = int'(wdata_i);
      if (we_i) begin
        if (a == A_MODE) begin
          if (m_mul) begin n_mode = d & 'hC003; acc = 1; end
        end
        if (a == A_LCFG && m_lul) n_lcfg = d & 'hFFFF;
        if (a == A_LCLK && m_lul) n_lclk = d & 1;
        if (a == A_STAT) n_err = n_err & ~(d & 3);
        if (a == A_MODE && !m_mul) n_err = n_err | 1;
        if ((a == A_LCFG || a == A_LCLK) && !m_lul) n_err = n_err | 2;
      end
      if (wake_i && m_st != 0 && !acc) n_mode = (m_mode & 'hC000) | 1;
      if (we_i) begin
        m_mul = (a == A_MKEY) && (wdata_i == K_MODE);
        m_lul = (a == A_LKEY) && (wdata_i == K_LP);
      end
      m_st = dec_state(m_mode);
      m_mode = n_mode; m_lcfg = n_lcfg; m_lclk = n_lclk; m_err = n_err;
    end
  end

  // per-cycle comparison, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R8 hs_clk_gate", 32'(hs_clk_gate_o), 32'(m_st != 0));
      chk("R9 ram_ret", 32'(ram_ret_o), 32'(m_st != 0 && m_mode[15]));
      chk("R9 adc_sw_on", 32'(adc_sw_on_o), 32'(m_st == 0 || m_mode[14]));
      chk("R10 lp_pd", 32'(lp_pd_o), (m_st == 2) ? 32'hFFFF : 32'(m_lcfg));
      chk("R11 sys_clk_lf", 32'(sys_clk_lf_o), 32'(m_st != 0 || (m_lclk[0] && seq_lf_req_i)));
      chk("R6 rdata model", rdata_o, 32'(mdl_read(int'(addr_i))));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk_i); #2;
    addr_i = ADDR_W'(a); wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #2;
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk_i); #2;
    addr_i = ADDR_W'(a);
    #1 chk(tag, rdata_o, exp);
  endtask

  task automatic settle();
    repeat (2) @(posedge clk_i);
    #2;
  endtask

  task automatic pulse_wake();
    @(posedge clk_i); #2 wake_i = 1'b1;
    @(posedge clk_i); #2 wake_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R1 reset state
    rd(A_MODE, 32'h1, "R1 mode reset");
    rd(A_LCFG, 32'h0, "R1 lp_cfg reset");
    rd(A_LCLK, 32'h0, "R1 lp_clk reset");
    rd(A_STAT, 32'h0, "R1 status reset");
    chk("R1 gate reset", 32'(hs_clk_gate_o), 32'h0);

    // R2 unkeyed mode write
    wr(A_MODE, 32'h2);
    rd(A_MODE, 32'h1, "R2 mode unchanged");
    rd(A_STAT, 32'h1, "R2 err bit0");
    // R13 clear
    wr(A_STAT, 32'h3);
    rd(A_STAT, 32'h0, "R13 err cleared");

    // R3 keyed entry to hibernate with both retentions
    wr(A_MKEY, K_MODE);
    wr(A_MODE, 32'hC002);
    rd(A_MODE, 32'hC002, "R3 keyed write");
    settle();
    chk("R8 gate in hib", 32'(hs_clk_gate_o), 32'h1);
    chk("R9 ram_ret hib", 32'(ram_ret_o), 32'h1);
    chk("R11 lf in hib", 32'(sys_clk_lf_o), 32'h1);
    rd(A_STAT, 32'h10, "R7 state hib");
    // R3 one-shot
    wr(A_MODE, 32'h0001);
    rd(A_MODE, 32'hC002, "R3 second write blocked");
    rd(A_STAT, 32'h11, "R3 err after second write");
    wr(A_STAT, 32'h1);

    // R12 wake
    pulse_wake();
    rd(A_MODE, 32'hC001, "R12 wake sets active");
    settle();
    chk("R12 gate off after wake", 32'(hs_clk_gate_o), 32'h0);
    pulse_wake();
    rd(A_MODE, 32'hC001, "R12 wake ignored when active");

    // R4 intervening write and wrong key
    wr(A_MKEY, K_MODE);
    wr(A_LKEY, 32'h0);
    wr(A_MODE, 32'h0002);
    rd(A_MODE, 32'hC001, "R4 intervening write relocks");
    wr(A_MKEY, K_MODE);
    wr(A_MKEY, 32'h4858);
    wr(A_MODE, 32'h0002);
    rd(A_MODE, 32'hC001, "R4 wrong key relocks");
    wr(A_STAT, 32'h3);

    // R5 / R6 low-power registers
    wr(A_LKEY, K_LP);
    wr(A_LCFG, 32'hFFFF_FFFF);
    rd(A_LCFG, 32'h0000_FFFF, "R6 lp_cfg width");
    wr(A_LCFG, 32'h0);
    rd(A_LCFG, 32'h0000_FFFF, "R5 lp_cfg blocked");
    rd(A_STAT, 32'h2, "R5 err bit1");
    wr(A_LKEY, K_LP);
    wr(A_LCLK, 32'hFFFF_FFFF);
    rd(A_LCLK, 32'h1, "R5 lp_clk keyed");
    @(posedge clk_i); #2 seq_lf_req_i = 1'b1;
    #3 chk("R11 seq switch", 32'(sys_clk_lf_o), 32'h1);
    @(posedge clk_i); #2 seq_lf_req_i = 1'b0;
    #3 chk("R11 seq released", 32'(sys_clk_lf_o), 32'h0);

    // R10 power-down mirror and shutdown forcing
    wr(A_LKEY, K_LP);
    wr(A_LCFG, 32'h2);
    settle();
    chk("R10 lp_pd mirror", 32'(lp_pd_o), 32'h2);
    wr(A_MKEY, K_MODE);
    wr(A_MODE, 32'h0003);
    settle();
    chk("R10 lp_pd shutdown", 32'(lp_pd_o), 32'hFFFF);
    chk("R9 adc off shutdown", 32'(adc_sw_on_o), 32'h0);
    rd(A_STAT, 32'h22, "R7 state shutdown");
    wr(A_STAT, 32'h2);
    rd(A_STAT, 32'h20, "R13 clear bit1 only");
    pulse_wake();
    settle();

    // R6 reserved mode bits dropped, key regs read zero
    wr(A_MKEY, K_MODE);
    wr(A_MODE, 32'hFFFF_3FFD);
    rd(A_MODE, 32'h0000_0001, "R6 reserved mode bits");
    rd(A_MKEY, 32'h0, "R6 key reads zero");
    rd(A_LKEY, 32'h0, "R6 lp key reads zero");
    settle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule